// File: doc/BRIEF.md
# Function-Level Reset Tracker

This block sits beside the configuration-write path of a PCIe endpoint that exposes several physical functions (PFs), each with a fixed pool of virtual functions (VFs). It watches every configuration write aimed at a function's Device Control register. When the write carries the initiate-reset bit (bit 15 of the written value), the block starts a function-level reset for the function that the write addresses.

A PF in reset gets a level flag that stays high until the application returns a completion for that PF. A VF in reset gets a single-cycle notice that carries its parent PF number and its VF offset. The VF stays marked as pending until a completion strobe names the same PF number and offset. For every function the block presents an enabled/disabled view. It also keeps two sticky error flags: one for completions that arrive after the deadline, and one for handshakes that break the protocol.

The deadline is a cycle count (`TIMEOUT_CYCLES`). Its default is 100 ms at 125 MHz, and it can be scaled down for simulation. A synchronous active-high reset clears all state.

Top module: `flr_tracker`

## Requirements
- R1: While `rst` is high and right after it, `pfResetActive` and `vfResetPulse` are 0, `pfEnabled` and `vfEnabled` are all ones, and both error flags are 0.
- R2: A write (`cfgWrValid`=1, `cfgWrIsVf`=0, `cfgWrFlrBit`=1) addressed to PF p raises `pfResetActive[p]` and drops `pfEnabled[p]` in the cycle after the write. Bit 0 is PF0, bit 1 is PF1, and so on.
- R3: `pfResetActive[p]` stays high until `pfResetDone[p]` is sampled high. It falls on that edge and `pfEnabled[p]` returns to 1. Holding `pfResetDone[p]` for further cycles sets no error.
- R4: A write with `cfgWrIsVf`=1 addressed to PF p and offset o produces `vfResetPulse` high for exactly one cycle, in the cycle after the write, with `vfResetPf`=p and `vfResetOfs`=o. Both fields read 0 when no pulse is present. The VF's enable bit is `vfEnabled[p*VF_PER_PF+o]`, and it reads 0 while that VF is pending.
- R5: A pending VF is cleared only by `vfDoneStrobe` with matching `vfDonePf` and `vfDoneOfs`. A strobe that names another VF leaves it pending.
- R6: A configuration write with `cfgWrFlrBit`=0 changes no output.
- R7: A reset-initiating write to a function that is already in reset is ignored: no new pulse is produced and the state is unchanged. It also sets `protoErr`.
- R8: A completion for a function that is not in reset is ignored and sets `protoErr`. For a PF this applies to a rising edge of `pfResetDone[p]`; for a VF it applies to any `vfDoneStrobe`.
- R9: If a function has not been completed by the `TIMEOUT_CYCLES`-th clock edge after the edge that started its reset, `timeoutErr` is set. A completion sampled on exactly that edge is on time.
- R10: `timeoutErr` and `protoErr` stay set until `rst`.
- R11: Each write and completion is judged against the state before the edge. Events in the same cycle that touch different functions all take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfgWrValid | input | 1 | Configuration write to a Device Control register |
| cfgWrIsVf | input | 1 | Write targets a VF (1) or a PF (0) |
| cfgWrPf | input | PF_W | PF number of the target |
| cfgWrVf | input | VF_W | VF offset of the target (VF writes only) |
| cfgWrFlrBit | input | 1 | Bit 15 of the written value |
| pfResetActive | output | NUM_PF | Per-PF reset-in-progress level |
| pfResetDone | input | NUM_PF | Per-PF completion from the application |
| pfEnabled | output | NUM_PF | PF enabled (1) or held in reset (0) |
| vfResetPulse | output | 1 | One-cycle VF reset notice |
| vfResetPf | output | PF_W | Parent PF of the notified VF |
| vfResetOfs | output | VF_W | Offset of the notified VF |
| vfDoneStrobe | input | 1 | One-cycle VF completion strobe |
| vfDonePf | input | PF_W | Parent PF of the completed VF |
| vfDoneOfs | input | VF_W | Offset of the completed VF |
| vfEnabled | output | NUM_PF*VF_PER_PF | Per-VF enabled flags, index p*VF_PER_PF+o |
| timeoutErr | output | 1 | Sticky late-completion flag |
| protoErr | output | 1 | Sticky protocol-violation flag |

## Verification
A reset-initiating write and a completion can arrive in the same cycle, on different functions or on the same one. The bench creates both cases. It starts a reset on a PF while completing a pending VF. It also re-writes a pending VF in the same cycle that its completion arrives. The first case must leave the PF active, the VF enabled and no error raised. The second case must clear the VF, emit no pulse and raise `protoErr`, because both events are judged against the state before the edge.

// File: rtl/flr_pkg.sv
package flr_pkg;
  // strobes from the decode logic into the state datapath
  typedef struct packed {
    logic protoErr;  // a handshake broke the protocol this cycle
    logic vfNotify;  // a VF reset was accepted this cycle
  } flrStrobe_t;
endpackage

// File: rtl/flr_ctrl.sv
module flr_ctrl
  import flr_pkg::*;
#(
  parameter int NUM_PF    = 2,
  parameter int VF_PER_PF = 4,
  parameter int PF_W      = 1,
  parameter int VF_W      = 2,
  parameter int NUM_FN    = NUM_PF + NUM_PF * VF_PER_PF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfgWrValid,
  input  logic              cfgWrIsVf,
  input  logic [PF_W-1:0]   cfgWrPf,
  input  logic [VF_W-1:0]   cfgWrVf,
  input  logic              cfgWrFlrBit,
  input  logic [NUM_PF-1:0] pfResetDone,
  input  logic              vfDoneStrobe,
  input  logic [PF_W-1:0]   vfDonePf,
  input  logic [VF_W-1:0]   vfDoneOfs,
  input  logic [NUM_FN-1:0] busy,
  output logic [NUM_FN-1:0] setMask,
  output logic [NUM_FN-1:0] clrMask,
  output flrStrobe_t        strobe
);
  logic [NUM_PF-1:0] pfDoneDly;
  logic [NUM_PF-1:0] pfDoneRise;

  always_ff @(posedge clk) begin
    if (rst) pfDoneDly <= '0;
    else     pfDoneDly <= pfResetDone;
  end

  assign pfDoneRise = pfResetDone & ~pfDoneDly;

  always_comb begin
    int  wrIdx;
    int  doneIdx;
    logic wrOk;
    logic doneOk;
    setMask = '0;
    clrMask = '0;
    strobe  = '0;
    // PF completions: level may be held, only a fresh edge can be stray
    for (int p = 0; p < NUM_PF; p++) begin
      if (pfResetDone[p] && busy[p]) clrMask[p] = 1'b1;
      else if (pfDoneRise[p] && !busy[p]) strobe.protoErr = 1'b1;
    end
    // reset-initiating configuration write
    if (cfgWrIsVf) begin
      wrIdx = NUM_PF + int'(cfgWrPf) * VF_PER_PF + int'(cfgWrVf);
      wrOk  = (int'(cfgWrPf) < NUM_PF) && (int'(cfgWrVf) < VF_PER_PF);
    end else begin
      wrIdx = int'(cfgWrPf);
      wrOk  = int'(cfgWrPf) < NUM_PF;
    end
    if (cfgWrValid && cfgWrFlrBit) begin
      if (!wrOk || busy[wrIdx]) strobe.protoErr = 1'b1;
      else begin
        setMask[wrIdx]  = 1'b1;
        strobe.vfNotify = cfgWrIsVf;
      end
    end
    // VF completion strobe
    doneIdx = NUM_PF + int'(vfDonePf) * VF_PER_PF + int'(vfDoneOfs);
    doneOk  = (int'(vfDonePf) < NUM_PF) && (int'(vfDoneOfs) < VF_PER_PF);
    if (vfDoneStrobe) begin
      if (doneOk && busy[doneIdx]) clrMask[doneIdx] = 1'b1;
      else strobe.protoErr = 1'b1;
    end
  end

  // R7: never start a reset on a function that is already in one
  p_no_restart_r7: assert property (@(posedge clk) disable iff (rst)
    (setMask & busy) == '0);
endmodule

// File: rtl/flr_state.sv
module flr_state
  import flr_pkg::*;
#(
  parameter int NUM_PF         = 2,
  parameter int VF_PER_PF      = 4,
  parameter int PF_W           = 1,
  parameter int VF_W           = 2,
  parameter int TIMEOUT_CYCLES = 12_500_000,
  parameter int NUM_FN         = NUM_PF + NUM_PF * VF_PER_PF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_FN-1:0] setMask,
  input  logic [NUM_FN-1:0] clrMask,
  input  flrStrobe_t        strobe,
  input  logic [PF_W-1:0]   cfgWrPf,
  input  logic [VF_W-1:0]   cfgWrVf,
  output logic [NUM_FN-1:0] busy,
  output logic              vfResetPulse,
  output logic [PF_W-1:0]   vfResetPf,
  output logic [VF_W-1:0]   vfResetOfs,
  output logic              timeoutErr,
  output logic              protoErr
);
  localparam int CNT_W = $clog2(TIMEOUT_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMEOUT_CYCLES - 1);

  logic [NUM_FN-1:0] lateHit;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy         <= '0;
      vfResetPulse <= 1'b0;
      vfResetPf    <= '0;
      vfResetOfs   <= '0;
      timeoutErr   <= 1'b0;
      protoErr     <= 1'b0;
    end else begin
      busy         <= (busy | setMask) & ~clrMask;
      vfResetPulse <= strobe.vfNotify;
      vfResetPf    <= strobe.vfNotify ? cfgWrPf : '0;
      vfResetOfs   <= strobe.vfNotify ? cfgWrVf : '0;
      timeoutErr   <= timeoutErr | (|lateHit);
      protoErr     <= protoErr | strobe.protoErr;
    end
  end

  // one deadline counter per function, saturating at the limit
  for (genvar f = 0; f < NUM_FN; f++) begin : g_fn
    logic [CNT_W-1:0] cnt;
    always_ff @(posedge clk) begin
      if (rst || !busy[f])  cnt <= '0;
      else if (cnt != LAST) cnt <= cnt + 1'b1;
    end
    assign lateHit[f] = busy[f] & ~clrMask[f] & (cnt == LAST);
  end

  // R9: a late flag only ever rises while some function was in reset
  p_late_needs_busy_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(timeoutErr) |-> $past(|busy));
  // R11: a clear only targets a function that is in reset
  p_clr_only_busy_r11: assert property (@(posedge clk) disable iff (rst)
    (clrMask & ~busy) == '0);
endmodule

// File: rtl/flr_tracker.sv
module flr_tracker
  import flr_pkg::*;
#(
  parameter int NUM_PF         = 2,
  parameter int VF_PER_PF      = 4,
  parameter int TIMEOUT_CYCLES = 12_500_000,
  localparam int PF_W   = (NUM_PF > 1) ? $clog2(NUM_PF) : 1,
  localparam int VF_W   = (VF_PER_PF > 1) ? $clog2(VF_PER_PF) : 1,
  localparam int NUM_VF = NUM_PF * VF_PER_PF,
  localparam int NUM_FN = NUM_PF + NUM_VF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfgWrValid,
  input  logic              cfgWrIsVf,
  input  logic [PF_W-1:0]   cfgWrPf,
  input  logic [VF_W-1:0]   cfgWrVf,
  input  logic              cfgWrFlrBit,
  output logic [NUM_PF-1:0] pfResetActive,
  input  logic [NUM_PF-1:0] pfResetDone,
  output logic [NUM_PF-1:0] pfEnabled,
  output logic              vfResetPulse,
  output logic [PF_W-1:0]   vfResetPf,
  output logic [VF_W-1:0]   vfResetOfs,
  input  logic              vfDoneStrobe,
  input  logic [PF_W-1:0]   vfDonePf,
  input  logic [VF_W-1:0]   vfDoneOfs,
  output logic [NUM_VF-1:0] vfEnabled,
  output logic              timeoutErr,
  output logic              protoErr
);
  logic [NUM_FN-1:0] busy;
  logic [NUM_FN-1:0] setMask;
  logic [NUM_FN-1:0] clrMask;
  flrStrobe_t        strobe;

  flr_ctrl #(
    .NUM_PF(NUM_PF), .VF_PER_PF(VF_PER_PF), .PF_W(PF_W), .VF_W(VF_W), .NUM_FN(NUM_FN)
  ) u_ctrl (
    .clk(clk), .rst(rst),
    .cfgWrValid(cfgWrValid), .cfgWrIsVf(cfgWrIsVf), .cfgWrPf(cfgWrPf),
    .cfgWrVf(cfgWrVf), .cfgWrFlrBit(cfgWrFlrBit),
    .pfResetDone(pfResetDone),
    .vfDoneStrobe(vfDoneStrobe), .vfDonePf(vfDonePf), .vfDoneOfs(vfDoneOfs),
    .busy(busy), .setMask(setMask), .clrMask(clrMask), .strobe(strobe)
  );

  flr_state #(
    .NUM_PF(NUM_PF), .VF_PER_PF(VF_PER_PF), .PF_W(PF_W), .VF_W(VF_W),
    .TIMEOUT_CYCLES(TIMEOUT_CYCLES), .NUM_FN(NUM_FN)
  ) u_state (
    .clk(clk), .rst(rst),
    .setMask(setMask), .clrMask(clrMask), .strobe(strobe),
    .cfgWrPf(cfgWrPf), .cfgWrVf(cfgWrVf),
    .busy(busy),
    .vfResetPulse(vfResetPulse), .vfResetPf(vfResetPf), .vfResetOfs(vfResetOfs),
    .timeoutErr(timeoutErr), .protoErr(protoErr)
  );

  assign pfResetActive = busy[NUM_PF-1:0];
  assign pfEnabled     = ~busy[NUM_PF-1:0];
  assign vfEnabled     = ~busy[NUM_FN-1:NUM_PF];

  // R3: a PF level only drops after its completion was seen
  for (genvar p = 0; p < NUM_PF; p++) begin : g_pfChk
    p_pf_sticky_r3: assert property (@(posedge clk) disable iff (rst)
      $fell(pfResetActive[p]) |-> $past(pfResetDone[p]));
  end
  // R4: the notified VF reads as disabled during its pulse
  p_vf_pulse_pending_r4: assert property (@(posedge clk) disable iff (rst)
    vfResetPulse |-> !vfEnabled[int'(vfResetPf) * VF_PER_PF + int'(vfResetOfs)]);
  // R10: error flags are sticky
  p_proto_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    protoErr |=> protoErr);
  p_late_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    timeoutErr |=> timeoutErr);
endmodule

// File: tb/flr_tracker_test.sv
module flr_tracker_test;
  localparam int NPF = 2;
  localparam int VPP = 4;
  localparam int TMO = 20;

  logic       clk = 1'b0;
  logic       rst;
  logic       cfgWrValid, cfgWrIsVf, cfgWrFlrBit;
  logic [0:0] cfgWrPf;
  logic [1:0] cfgWrVf;
  logic [1:0] pfResetActive, pfResetDone, pfEnabled;
  logic       vfResetPulse;
  logic [0:0] vfResetPf;
  logic [1:0] vfResetOfs;
  logic       vfDoneStrobe;
  logic [0:0] vfDonePf;
  logic [1:0] vfDoneOfs;
  logic [7:0] vfEnabled;
  logic       timeoutErr, protoErr;

  int nChecks = 0;
  int nFail   = 0;

  always #4 clk = ~clk;  // 125 MHz

  flr_tracker #(.NUM_PF(NPF), .VF_PER_PF(VPP), .TIMEOUT_CYCLES(TMO)) uut (
    .clk(clk), .rst(rst),
    .cfgWrValid(cfgWrValid), .cfgWrIsVf(cfgWrIsVf), .cfgWrPf(cfgWrPf),
    .cfgWrVf(cfgWrVf), .cfgWrFlrBit(cfgWrFlrBit),
    .pfResetActive(pfResetActive), .pfResetDone(pfResetDone), .pfEnabled(pfEnabled),
    .vfResetPulse(vfResetPulse), .vfResetPf(vfResetPf), .vfResetOfs(vfResetOfs),
    .vfDoneStrobe(vfDoneStrobe), .vfDonePf(vfDonePf), .vfDoneOfs(vfDoneOfs),
    .vfEnabled(vfEnabled), .timeoutErr(timeoutErr), .protoErr(protoErr)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic idleInputs();
    cfgWrValid = 0; cfgWrIsVf = 0; cfgWrFlrBit = 0; cfgWrPf = 0; cfgWrVf = 0;
    pfResetDone = 0; vfDoneStrobe = 0; vfDonePf = 0; vfDoneOfs = 0;
  endtask

  task automatic doReset();
    @(negedge clk);
    idleInputs();
    rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
  endtask

  // drive for one edge, return at the negedge after it
  task automatic cfgWrite(input logic isVf, input int pf, input int ofs, input logic flr);
    @(negedge clk);
    cfgWrValid = 1; cfgWrIsVf = isVf; cfgWrPf = pf[0:0]; cfgWrVf = ofs[1:0]; cfgWrFlrBit = flr;
    @(negedge clk);
    cfgWrValid = 0; cfgWrFlrBit = 0;
  endtask

  task automatic vfDone(input int pf, input int ofs);
    @(negedge clk);
    vfDoneStrobe = 1; vfDonePf = pf[0:0]; vfDoneOfs = ofs[1:0];
    @(negedge clk);
    vfDoneStrobe = 0;
  endtask

  task automatic t_reset();
    rst = 1; idleInputs();
    repeat (2) @(negedge clk);
    check("R1", "active in reset", int'(pfResetActive), 0);
    rst = 0;
    @(negedge clk);
    check("R1", "active", int'(pfResetActive), 0);
    check("R1", "pfEnabled", int'(pfEnabled), 3);
    check("R1", "vfEnabled", int'(vfEnabled), 'hFF);
    check("R1", "pulse", int'(vfResetPulse), 0);
    check("R1", "errors", int'({timeoutErr, protoErr}), 0);
  endtask

  task automatic t_pf();
    doReset();
    cfgWrite(0, 1, 0, 1);
    check("R2", "active after PF1 write", int'(pfResetActive), 2);
    check("R2", "pfEnabled", int'(pfEnabled), 1);
    repeat (3) @(negedge clk);
    check("R3", "active still held", int'(pfResetActive), 2);
    pfResetDone = 2'b10;
    @(negedge clk);
    check("R3", "active cleared by done", int'(pfResetActive), 0);
    check("R3", "pfEnabled back", int'(pfEnabled), 3);
    repeat (2) @(negedge clk);
    pfResetDone = 0;
    @(negedge clk);
    check("R3", "held done no error", int'(protoErr), 0);
  endtask

  task automatic t_vf();
    doReset();
    cfgWrite(1, 1, 3, 1);
    check("R4", "pulse", int'(vfResetPulse), 1);
    check("R4", "pulse pf", int'(vfResetPf), 1);
    check("R4", "pulse ofs", int'(vfResetOfs), 3);
    check("R4", "vfEnabled", int'(vfEnabled), 'h7F);
    @(negedge clk);
    check("R4", "pulse one wide", int'(vfResetPulse), 0);
    check("R4", "fields idle", int'({vfResetPf, vfResetOfs}), 0);
    vfDone(1, 2);
    check("R5", "wrong offset keeps pending", int'(vfEnabled), 'h7F);
    check("R5", "wrong offset error", int'(protoErr), 1);
    vfDone(1, 3);
    check("R5", "matching done clears", int'(vfEnabled), 'hFF);
  endtask

  task automatic t_noBit();
    doReset();
    cfgWrite(0, 0, 0, 0);
    check("R6", "PF write no bit", int'(pfResetActive), 0);
    cfgWrite(1, 0, 2, 0);
    check("R6", "VF write no bit pulse", int'(vfResetPulse), 0);
    check("R6", "VF write no bit state", int'(vfEnabled), 'hFF);
    check("R6", "no error", int'(protoErr), 0);
  endtask

  task automatic t_dup();
    doReset();
    cfgWrite(1, 0, 1, 1);
    @(negedge clk);
    cfgWrite(1, 0, 1, 1);
    check("R7", "repeat VF write no pulse", int'(vfResetPulse), 0);
    check("R7", "repeat VF still pending", int'(vfEnabled), 'hFD);
    check("R7", "repeat VF error", int'(protoErr), 1);
    doReset();
    cfgWrite(0, 0, 0, 1);
    cfgWrite(0, 0, 0, 1);
    check("R7", "repeat PF active", int'(pfResetActive), 1);
    check("R7", "repeat PF error", int'(protoErr), 1);
  endtask

  task automatic t_stray();
    doReset();
    @(negedge clk); pfResetDone = 2'b01;
    @(negedge clk); pfResetDone = 0;
    check("R8", "stray PF done error", int'(protoErr), 1);
    check("R8", "stray PF done ignored", int'(pfResetActive), 0);
    repeat (5) @(negedge clk);
    check("R10", "protoErr sticky", int'(protoErr), 1);
    doReset();
    check("R10", "protoErr cleared by reset", int'(protoErr), 0);
    vfDone(0, 0);
    check("R8", "stray VF done error", int'(protoErr), 1);
    check("R8", "stray VF done ignored", int'(vfEnabled), 'hFF);
  endtask

  task automatic t_deadline();
    doReset();
    @(negedge clk);
    cfgWrValid = 1; cfgWrFlrBit = 1; cfgWrIsVf = 0; cfgWrPf = 0;
    @(negedge clk);
    cfgWrValid = 0; cfgWrFlrBit = 0;
    repeat (TMO - 1) @(negedge clk);
    pfResetDone = 2'b01;
    @(negedge clk);
    pfResetDone = 0;
    check("R9", "done on last edge is on time", int'(timeoutErr), 0);
    check("R9", "done cleared", int'(pfResetActive), 0);
    doReset();
    @(negedge clk);
    cfgWrValid = 1; cfgWrFlrBit = 1; cfgWrIsVf = 1; cfgWrPf = 1; cfgWrVf = 0;
    @(negedge clk);
    cfgWrValid = 0; cfgWrFlrBit = 0;
    repeat (TMO) @(negedge clk);
    vfDoneStrobe = 1; vfDonePf = 1; vfDoneOfs = 0;
    @(negedge clk);
    vfDoneStrobe = 0;
    check("R9", "one edge late flags", int'(timeoutErr), 1);
    check("R9", "late done still clears", int'(vfEnabled), 'hFF);
    repeat (4) @(negedge clk);
    check("R10", "timeoutErr sticky", int'(timeoutErr), 1);
  endtask

  task automatic t_sameCycle();
    doReset();
    cfgWrite(1, 0, 1, 1);
    @(negedge clk);
    cfgWrValid = 1; cfgWrFlrBit = 1; cfgWrIsVf = 0; cfgWrPf = 0;
    vfDoneStrobe = 1; vfDonePf = 0; vfDoneOfs = 1;
    @(negedge clk);
    idleInputs();
    check("R11", "PF started with VF done", int'(pfResetActive), 1);
    check("R11", "VF cleared with PF write", int'(vfEnabled), 'hFF);
    check("R11", "no error", int'(protoErr), 0);
    doReset();
    cfgWrite(1, 0, 1, 1);
    @(negedge clk);
    cfgWrValid = 1; cfgWrFlrBit = 1; cfgWrIsVf = 1; cfgWrPf = 0; cfgWrVf = 1;
    vfDoneStrobe = 1; vfDonePf = 0; vfDoneOfs = 1;
    @(negedge clk);
    idleInputs();
    check("R11", "same VF no pulse", int'(vfResetPulse), 0);
    check("R11", "same VF cleared", int'(vfEnabled), 'hFF);
    check("R11", "same VF error", int'(protoErr), 1);
  endtask

  initial begin
    #(8 * 100000);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    t_reset();
    t_pf();
    t_vf();
    t_noBit();
    t_dup();
    t_stray();
    t_deadline();
    t_sameCycle();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end
endmodule